// File: doc/BRIEF.md
# Interrupt-Capable GPIO Controller

This block serves 32 general-purpose pins from one word-addressed register bus. Software picks each pin's direction and drives the output latch only through two write-one ports, one that raises bits and one that lowers them. It reads back the pin levels after a two-flop synchronizer.

Every pin also has an event detector. Three per-pin configuration bits select the trigger. One picks level or edge. One picks single or double edge. One picks polarity: rising or active-high, versus falling or active-low. Detected events go into a raw status word. An enable word and a mask word gate that status into a masked status word, and the masked bits are ORed into one interrupt line. A write-one acknowledge port clears latched edge events.

The bus is a plain request interface. Each cycle with `bus_valid` high is one access. Writes take effect at that clock edge. Read data appears on `bus_rdata` on the following cycle.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, direction, output latch, enable, mask, trigger configuration and raw status are all zero, and `irq` is low.
- R2: The word at offset 0x08 is the direction register. A 1 bit makes that pin an output and drives `pin_oe` high. The register reads back what was written.
- R3: Writing to offset 0x10 sets the output latch bits where the written word is 1. Writing to offset 0x14 clears them where the written word is 1. All other latch bits keep their value, and reading 0x10 or 0x14 returns the latch.
- R4: Reading offset 0x04 returns `pin_in` after two synchronizer flops. Any read returns its data on `bus_rdata` one cycle after the request.
- R5: A pin with trigger-method bit 0 (offset 0x34) and both-edges bit 0 (offset 0x38) is in single-edge mode. Its polarity bit (offset 0x3C) selects rising (0) or falling (1). A detected edge sets the pin's bit in raw status (offset 0x24), and the bit stays set until acknowledged.
- R6: In edge mode with the both-edges bit at 1, rising and falling edges both set raw status, whatever the polarity bit holds.
- R7: With the trigger-method bit at 1, the raw status bit tracks the active level: high for polarity 0, low for polarity 1. While the level stays active the bit cannot stay cleared, even straight after an acknowledge.
- R8: Writing to offset 0x30 clears latched edge events where the written word is 1. Bits written as 0 leave status unchanged.
- R9: If an edge is detected in the same cycle that its acknowledge bit is written, the event wins and the raw status bit stays set.
- R10: Masked status (offset 0x28) is raw status AND enable (offset 0x20) AND NOT mask (offset 0x2C). `irq` is high exactly when any masked bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read request |
| pin_in | input | 32 | Asynchronous pin levels |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Per-pin output enable (direction) |
| irq | output | 1 | Combined interrupt |

## Verification
Several properties are checked on every cycle. Edge events are latched into raw status. A latched edge bit falls only after an acknowledge. Level-mode status follows the active condition. The set, clear and direction writes land in the latch and enables, and `irq` only rises with an unmasked raw bit. The bench shows what needs a chosen stimulus: the meaning of each trigger-mode combination, the timing of the synchronizer, an event colliding with its acknowledge in one cycle, and acknowledge writes of zero leaving status alone.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_PINS  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIR   = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SET   = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_CLR   = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_EN    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h24;
  localparam logic [ADDR_W-1:0] OFS_MSKD  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_MASK  = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_ACK   = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_METH  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_BOTH  = 8'h38;
  localparam logic [ADDR_W-1:0] OFS_POL   = 8'h3C;

  typedef struct packed {
    logic dir;
    logic set;
    logic clr;
    logic en;
    logic mask;
    logic ack;
    logic meth;
    logic both;
    logic pol;
  } wr_sel_t;

  function automatic wr_sel_t decode_wr(input logic [ADDR_W-1:0] a);
    wr_sel_t s;
    s = '0;
    case (a)
      OFS_DIR:  s.dir  = 1'b1;
      OFS_SET:  s.set  = 1'b1;
      OFS_CLR:  s.clr  = 1'b1;
      OFS_EN:   s.en   = 1'b1;
      OFS_MASK: s.mask = 1'b1;
      OFS_ACK:  s.ack  = 1'b1;
      OFS_METH: s.meth = 1'b1;
      OFS_BOTH: s.both = 1'b1;
      OFS_POL:  s.pol  = 1'b1;
      default:  s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] lvl_mode,
  input  logic [W-1:0] both_edge,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] ack_bits,
  output logic [W-1:0] raw_q,
  output logic [W-1:0] edge_hit,
  output logic [W-1:0] lvl_act
);
  logic [W-1:0] prev_q;

  function automatic logic edge_sel(input logic cur, input logic prv,
                                    input logic both, input logic p);
    logic rise, fall;
    rise = cur & ~prv;
    fall = ~cur & prv;
    if (both) return rise | fall;
    return p ? fall : rise;
  endfunction

  function automatic logic lvl_sel(input logic cur, input logic p);
    return p ? ~cur : cur;
  endfunction

  for (genvar i = 0; i < W; i++) begin : g_pin
    assign edge_hit[i] = edge_sel(pin_s[i], prev_q[i], both_edge[i], pol[i]);
    assign lvl_act[i]  = lvl_sel(pin_s[i], pol[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= pin_s;
      raw_q  <= (lvl_mode & lvl_act) |
                (~lvl_mode & (edge_hit | (raw_q & ~ack_bits)));
    end
  end

  // R5
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(edge_hit & ~lvl_mode)) == $past(edge_hit & ~lvl_mode)));

  // R8
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~raw_q & $past(raw_q & ~lvl_mode & ~ack_bits)) == '0));

  // R7
  lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((raw_q & $past(lvl_mode)) == $past(lvl_act & lvl_mode)));
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_in,
  output logic [W-1:0]      pin_out,
  output logic [W-1:0]      pin_oe,
  output logic              irq
);
  wr_sel_t      sel;
  logic         rd_req;
  logic [W-1:0] dir_q, out_q, en_q, mask_q, meth_q, both_q, pol_q;
  logic [W-1:0] pin_sync, raw_q, edge_hit, lvl_act, ack_bits, masked;
  logic [W-1:0] rd_val;

  assign sel      = (bus_valid && bus_write) ? decode_wr(bus_addr) : '0;
  assign rd_req   = bus_valid && !bus_write;
  assign ack_bits = sel.ack ? bus_wdata : '0;

  gpio_in_sync #(.W(W), .STAGES(2)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync)
  );

  gpio_trig_detect #(.W(W)) i_detect (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_sync),
    .lvl_mode(meth_q), .both_edge(both_q), .pol(pol_q),
    .ack_bits(ack_bits), .raw_q(raw_q),
    .edge_hit(edge_hit), .lvl_act(lvl_act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      en_q   <= '0;
      mask_q <= '0;
      meth_q <= '0;
      both_q <= '0;
      pol_q  <= '0;
    end else begin
      if (sel.dir)  dir_q  <= bus_wdata;
      if (sel.en)   en_q   <= bus_wdata;
      if (sel.mask) mask_q <= bus_wdata;
      if (sel.meth) meth_q <= bus_wdata;
      if (sel.both) both_q <= bus_wdata;
      if (sel.pol)  pol_q  <= bus_wdata;
      if (sel.set)      out_q <= out_q | bus_wdata;
      else if (sel.clr) out_q <= out_q & ~bus_wdata;
    end
  end

  assign masked  = raw_q & en_q & ~mask_q;
  assign irq     = |masked;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_comb begin
    case (bus_addr)
      OFS_PINS: rd_val = pin_sync;
      OFS_DIR:  rd_val = dir_q;
      OFS_SET,
      OFS_CLR:  rd_val = out_q;
      OFS_EN:   rd_val = en_q;
      OFS_RAW:  rd_val = raw_q;
      OFS_MSKD: rd_val = masked;
      OFS_MASK: rd_val = mask_q;
      OFS_METH: rd_val = meth_q;
      OFS_BOTH: rd_val = both_q;
      OFS_POL:  rd_val = pol_q;
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (rd_req) bus_rdata <= rd_val;
  end

  // R3
  set_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel.set |=> ((pin_out & $past(bus_wdata)) == $past(bus_wdata)));

  // R3
  clr_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel.clr |=> ((pin_out & $past(bus_wdata)) == '0));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel.dir |=> (pin_oe == $past(bus_wdata)));

  // R10
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((raw_q & en_q & ~mask_q) != '0));
endmodule

// File: tb/test_gpio_irq_ctrl.sv
`timescale 1ns/1ps
module test_gpio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic        bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out, pin_oe;
  logic        irq;
  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_irq_ctrl i_gpio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // vector bits: {level, both, polarity, pin start, pin end, expected raw}
  localparam logic [5:0] VEC [10] = '{
    6'b000011, 6'b000100, 6'b001101, 6'b001010, 6'b010011,
    6'b010101, 6'b100011, 6'b100100, 6'b101101, 6'b101010
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    idle(3);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    chk("R1 oe", pin_oe, 32'h0);
    chk("R1 out", pin_out, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(8'h24, r); chk("R1 raw", r, 32'h0);
    rd(8'h34, r); chk("R1 method", r, 32'h0);

    // R5 R6 R7 trigger-mode table on pin 0
    foreach (VEC[k]) begin
      @(negedge clk) pin_in[0] = VEC[k][2];
      idle(4);
      wr(8'h34, {31'b0, VEC[k][5]});
      wr(8'h38, {31'b0, VEC[k][4]});
      wr(8'h3C, {31'b0, VEC[k][3]});
      idle(4);
      wr(8'h30, 32'h1);
      idle(2);
      @(negedge clk) pin_in[0] = VEC[k][1];
      idle(5);
      rd(8'h24, r);
      chk($sformatf("R5 R6 R7 vector %0d", k), {31'b0, r[0]}, {31'b0, VEC[k][0]});
    end

    // back to rising edge everywhere, quiet pins, clear all
    @(negedge clk) pin_in = '0;
    wr(8'h34, 32'h0); wr(8'h38, 32'h0); wr(8'h3C, 32'h0);
    idle(5);
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h24, r); chk("R8 all cleared", r, 32'h0);

    // R2 direction
    wr(8'h08, 32'h0000_FFFF);
    chk("R2 oe", pin_oe, 32'h0000_FFFF);
    rd(8'h08, r); chk("R2 readback", r, 32'h0000_FFFF);

    // R3 set / clear ports
    wr(8'h10, 32'h0000_00FF);
    wr(8'h10, 32'h0000_0F00);
    chk("R3 set", pin_out, 32'h0000_0FFF);
    wr(8'h14, 32'h0000_0F0F);
    chk("R3 clear", pin_out, 32'h0000_00F0);
    rd(8'h14, r); chk("R3 readback", r, 32'h0000_00F0);

    // R4 synchronized readback
    @(negedge clk) pin_in = 32'hA5A5_5A5A;
    idle(3);
    rd(8'h04, r); chk("R4 input", r, 32'hA5A5_5A5A);
    @(negedge clk) pin_in = '0;
    idle(5);
    wr(8'h30, 32'hFFFF_FFFF);

    // R10 masked status and irq on pin 5
    wr(8'h20, 32'h0000_0020);
    @(negedge clk) pin_in[5] = 1'b1;
    idle(5);
    #1 chk("R10 irq up", {31'b0, irq}, 32'h1);
    rd(8'h28, r); chk("R10 masked", r, 32'h0000_0020);
    wr(8'h2C, 32'h0000_0020);
    #1 chk("R10 irq masked", {31'b0, irq}, 32'h0);
    rd(8'h28, r); chk("R10 masked off", r, 32'h0);
    rd(8'h24, r); chk("R10 raw kept", r, 32'h0000_0020);
    wr(8'h2C, 32'h0);
    wr(8'h20, 32'h0);
    #1 chk("R10 disabled", {31'b0, irq}, 32'h0);
    wr(8'h20, 32'h0000_0020);

    // R8 zero-write acknowledge has no effect, one-write clears
    wr(8'h30, 32'hFFFF_FFDF);
    rd(8'h24, r); chk("R8 zero ack", r, 32'h0000_0020);
    wr(8'h30, 32'h0000_0020);
    rd(8'h24, r); chk("R8 ack", r, 32'h0);
    #1 chk("R8 irq low", {31'b0, irq}, 32'h0);

    // R9 edge collides with acknowledge
    @(negedge clk) pin_in[9] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    wr(8'h30, 32'h0000_0200);
    rd(8'h24, r); chk("R9 event wins", r, 32'h0000_0200);

    // R7 level re-asserts after acknowledge
    wr(8'h34, 32'h0000_0080);
    @(negedge clk) pin_in[7] = 1'b1;
    idle(5);
    wr(8'h30, 32'h0000_0080);
    rd(8'h24, r); chk("R7 level stays", r & 32'h80, 32'h80);
    @(negedge clk) pin_in[7] = 1'b0;
    idle(5);
    rd(8'h24, r); chk("R7 level drops", r & 32'h80, 32'h0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule